// File: doc/BRIEF.md
# Debug control-register read responder

This block answers one debug-port command: read a control register chosen by a 32-bit select code. The host talks to it in 16-bit word exchanges over a full-duplex link. In each exchange the host hands over one word and gets back one 17-bit response frame. That frame always reports the state left by the previous exchange, not the word being sent in the current one.

A read takes a fixed run of exchanges:

- The host sends the command word.
- It then sends the upper half of the select code, then the lower half.
- It then keeps polling until the answer is no longer "not ready".

The block sends a frame that reads "not ready" the whole time it is collecting the operand and the register access is in flight. The access is a one-cycle request to a small modelled register bank, which answers after a configurable number of wait cycles. The result then comes back as two data frames, upper half first. If the select code matches no register, one bus-error frame is sent in place of the two data frames. The exchange that returns the last frame of a read (the lower result half, or the bus error) also carries the next command word, so reads can be chained back to back.

The modelled registers are constants and have different widths. Only the implemented low bits of a narrow register are defined. The returned bits above that width carry no meaning.

Top module: `dbg_creg_reader`

## Requirements
- R1: While the block waits for a command, only the word CMD_OPCODE (default 16'h2D80) starts a read. Any other word is ignored and the response stays "not ready".
- R2: Each response is 17 bits: bit 16 is status and bits 15:0 are data. "Not ready" is 17'h10000, bus error is 17'h10001, and a data frame has bit 16 clear with the data in bits 15:0.
- R3: The two exchanges after the command word supply the select code: the first carries bits 31:16 and the second carries bits 15:0.
- R4: Every exchange that follows the command word, the upper select word or the lower select word answers "not ready". While the access is outstanding the block keeps answering "not ready". When the host exchanges on every cycle right after the lower-select exchange, exactly WAIT_CYCLES+1 polls answer "not ready".
- R5: A successful read returns two consecutive data frames: result bits 31:16 first, then bits 15:0.
- R6: Register k (0 <= k < N_REGS) answers at select code SEL_BASE + k*SEL_STRIDE (defaults 32'h0000_0C00 and 4). Its width is 32 - 8*(k mod 4) bits. Its content is the low bits of 32'h1357_9BDF*(k+1) truncated to that width. Returned bits above that width are unspecified.
- R7: A select code that matches no register produces one bus-error frame in place of both data frames.
- R8: Words sent during the access wait and during the upper-result exchange are ignored. The word sent in the exchange that returns the lower result half, or the bus error, is taken as the next command word.
- R9: Reset at any point returns the block to waiting for a command, with the response "not ready".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xchg_i | input | 1 | One-cycle strobe marking a word exchange |
| word_i | input | 16 | Word sent by the host in this exchange |
| resp_o | output | 17 | Response frame returned in this exchange (status bit 16, data bits 15:0) |

## Verification
The assertions assume the register bank sees at most one request at a time and that an acknowledge comes only while the controller is waiting for one. Both hold as long as the host does not start a new read before the current one has delivered its final frame. The stimulus keeps to this by running each read to its last frame before sending the next command. It also polls on every cycle, so the count of "not ready" answers can be compared exactly with WAIT_CYCLES. The sweep covers every select code in and just around the mapped range, plus codes with high bits set. Each code is read both standalone and chained, and resets are placed in the middle of a read.

// File: rtl/dbg_creg_pkg.sv
package dbg_creg_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned SEL_W  = 32;
  localparam int unsigned RESP_W = WORD_W + 1;

  localparam logic [WORD_W-1:0] NRDY_CODE = 16'h0000;
  localparam logic [WORD_W-1:0] BERR_CODE = 16'h0001;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADR_HI,
    ST_ADR_LO,
    ST_READ,
    ST_RES_HI,
    ST_RES_LO,
    ST_BERR
  } fsm_state_e;

  typedef enum logic [1:0] {
    RK_NRDY,
    RK_BERR,
    RK_DATA
  } resp_kind_e;

  function automatic int unsigned creg_width(int unsigned k);
    return 32 - 8 * (k % 4);
  endfunction

  function automatic logic [SEL_W-1:0] creg_mask(int unsigned k);
    int unsigned w;
    w = creg_width(k);
    if (w >= 32) return '1;
    return (32'h1 << w) - 32'h1;
  endfunction

  function automatic logic [SEL_W-1:0] creg_value(int unsigned k);
    logic [SEL_W-1:0] raw;
    raw = 32'h1357_9BDF * (k + 1);
    return raw & creg_mask(k);
  endfunction

endpackage

// File: rtl/dbg_creg_file.sv
module dbg_creg_file
  import dbg_creg_pkg::*;
#(
  parameter int unsigned      N_REGS      = 4,
  parameter int unsigned      WAIT_CYCLES = 3,
  parameter logic [SEL_W-1:0] SEL_BASE    = 32'h0000_0C00,
  parameter int unsigned      SEL_STRIDE  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             ack_o,
  output logic             err_o,
  output logic [SEL_W-1:0] rdata_o
);

  localparam int unsigned CNT_W = (WAIT_CYCLES > 0) ? $clog2(WAIT_CYCLES + 1) : 1;

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic [N_REGS-1:0] hit;
  logic [SEL_W-1:0] data_k [N_REGS];
  logic [SEL_W-1:0] rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sel_q  <= '0;
    end else if (req_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(WAIT_CYCLES);
      sel_q  <= sel_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign ack_o = busy_q && (cnt_q == '0);

  for (genvar k = 0; k < N_REGS; k++) begin : g_reg
    localparam logic [SEL_W-1:0] CODE = SEL_BASE + SEL_W'(SEL_STRIDE * k);
    assign hit[k]    = (sel_q == CODE);
    assign data_k[k] = hit[k] ? creg_value(k) : '0;
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < N_REGS; k++) rd_mux = rd_mux | data_k[k];
  end

  assign err_o   = ack_o && !(|hit);
  assign rdata_o = ack_o ? rd_mux : '0;

  AST_NO_REQ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> !busy_q); // R4

  AST_ERR_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && err_o) |-> (rdata_o == '0)); // R7

endmodule

// File: rtl/dbg_word_fsm.sv
module dbg_word_fsm
  import dbg_creg_pkg::*;
#(
  parameter logic [WORD_W-1:0] CMD_OPCODE = 16'h2D80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xchg_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              req_o,
  output logic [SEL_W-1:0]  sel_o,
  input  logic              ack_i,
  input  logic              err_i,
  input  logic [SEL_W-1:0]  rdata_i,
  output resp_kind_e        kind_o,
  output logic [WORD_W-1:0] data_o
);

  fsm_state_e        state_q, state_d;
  resp_kind_e        kind_q, kind_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic [WORD_W-1:0] lo_q, lo_d;
  logic [WORD_W-1:0] hi_q, hi_d;
  logic              is_cmd;

  assign is_cmd = (word_i == CMD_OPCODE);
  assign req_o  = xchg_i && (state_q == ST_ADR_LO);
  assign sel_o  = {hi_q, word_i};

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    data_d  = data_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    unique case (state_q)
      ST_CMD: begin
        if (xchg_i && is_cmd) state_d = ST_ADR_HI;
      end
      ST_ADR_HI: begin
        if (xchg_i) begin
          hi_d    = word_i;
          state_d = ST_ADR_LO;
        end
      end
      ST_ADR_LO: begin
        if (xchg_i) state_d = ST_READ;
      end
      ST_READ: begin
        // host words during the wait are dropped
        if (ack_i) begin
          if (err_i) begin
            kind_d  = RK_BERR;
            state_d = ST_BERR;
          end else begin
            kind_d  = RK_DATA;
            data_d  = rdata_i[SEL_W-1:WORD_W];
            lo_d    = rdata_i[WORD_W-1:0];
            state_d = ST_RES_HI;
          end
        end
      end
      ST_RES_HI: begin
        if (xchg_i) begin
          data_d  = lo_q;
          state_d = ST_RES_LO;
        end
      end
      ST_RES_LO, ST_BERR: begin
        // final frame's exchange carries the next command
        if (xchg_i) begin
          kind_d  = RK_NRDY;
          data_d  = '0;
          state_d = is_cmd ? ST_ADR_HI : ST_CMD;
        end
      end
      default: state_d = ST_CMD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;
      kind_q  <= RK_NRDY;
      data_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      data_q  <= data_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
    end
  end

  assign kind_o = kind_q;
  assign data_o = data_q;

  AST_NRDY_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_ADR_HI, ST_ADR_LO, ST_READ}) |-> (kind_q == RK_NRDY)); // R4

  AST_ACK_ONLY_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> (state_q == ST_READ)); // R4

  AST_REQ_TO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> (state_q == ST_READ)); // R3

  AST_LO_AFTER_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RES_LO) |-> ($past(state_q) == ST_RES_HI)); // R5

  AST_ERR_TO_BERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READ && ack_i && err_i) |=> (kind_q == RK_BERR)); // R7

endmodule

// File: rtl/dbg_resp_enc.sv
module dbg_resp_enc
  import dbg_creg_pkg::*;
(
  input  resp_kind_e        kind_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [RESP_W-1:0] resp_o
);

  always_comb begin
    unique case (kind_i)
      RK_NRDY: resp_o = {1'b1, NRDY_CODE};
      RK_BERR: resp_o = {1'b1, BERR_CODE};
      default: resp_o = {1'b0, data_i};
    endcase
  end

endmodule

// File: rtl/dbg_creg_reader.sv
module dbg_creg_reader
  import dbg_creg_pkg::*;
#(
  parameter int unsigned       N_REGS      = 4,
  parameter int unsigned       WAIT_CYCLES = 3,
  parameter logic [31:0]       SEL_BASE    = 32'h0000_0C00,
  parameter int unsigned       SEL_STRIDE  = 4,
  parameter logic [15:0]       CMD_OPCODE  = 16'h2D80
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        xchg_i,
  input  logic [15:0] word_i,
  output logic [16:0] resp_o
);

  logic              req;
  logic [SEL_W-1:0]  sel;
  logic              ack;
  logic              err;
  logic [SEL_W-1:0]  rdata;
  resp_kind_e        kind;
  logic [WORD_W-1:0] data;

  dbg_word_fsm #(
    .CMD_OPCODE(CMD_OPCODE)
  ) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .xchg_i (xchg_i),
    .word_i (word_i),
    .req_o  (req),
    .sel_o  (sel),
    .ack_i  (ack),
    .err_i  (err),
    .rdata_i(rdata),
    .kind_o (kind),
    .data_o (data)
  );

  dbg_creg_file #(
    .N_REGS     (N_REGS),
    .WAIT_CYCLES(WAIT_CYCLES),
    .SEL_BASE   (SEL_BASE),
    .SEL_STRIDE (SEL_STRIDE)
  ) u_file (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .sel_i  (sel),
    .ack_o  (ack),
    .err_o  (err),
    .rdata_o(rdata)
  );

  dbg_resp_enc u_enc (
    .kind_i(kind),
    .data_i(data),
    .resp_o(resp_o)
  );

  AST_FRAME_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_o[16] |-> (resp_o[15:1] == '0)); // R2

endmodule

// File: tb/dbg_creg_reader_bench.sv
module dbg_creg_reader_bench;

  localparam int unsigned N      = 4;
  localparam int unsigned WAIT   = 3;
  localparam logic [31:0] BASE   = 32'h0000_0C00;
  localparam int unsigned STRIDE = 4;
  localparam logic [15:0] CMD    = 16'h2D80;
  localparam logic [16:0] NRDY   = 17'h10000;
  localparam logic [16:0] BERR   = 17'h10001;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xchg_i = 1'b0;
  logic [15:0] word_i = '0;
  logic [16:0] resp_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dbg_creg_reader u_dbg_creg_reader (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .xchg_i(xchg_i),
    .word_i(word_i),
    .resp_o(resp_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xchg(input logic [15:0] w, output logic [16:0] r);
    @(negedge clk);
    xchg_i = 1'b1;
    word_i = w;
    r = resp_o;
    @(posedge clk);
    #1;
    xchg_i = 1'b0;
  endtask

  function automatic bit lookup(input logic [31:0] sel, output int k);
    logic [31:0] d;
    k = 0;
    if (sel < BASE) return 0;
    d = sel - BASE;
    if ((d % STRIDE) != 0) return 0;
    if ((d / STRIDE) >= N) return 0;
    k = int'(d / STRIDE);
    return 1;
  endfunction

  // one read; first: send command; chain: polls and final word carry CMD
  task automatic rd(input logic [31:0] sel, input bit first, input bit chain);
    logic [16:0] r;
    logic [15:0] pw, hi;
    logic [31:0] m, exp, val, raw;
    int n, k;
    bit hit;
    pw  = chain ? CMD : 16'h0000;
    hit = lookup(sel, k);
    if (first) begin
      xchg(CMD, r);
      chk(r == NRDY, "R1", 32'(r), 32'(NRDY));
    end
    xchg(sel[31:16], r);
    chk(r == NRDY, first ? "R3" : "R8", 32'(r), 32'(NRDY));
    xchg(sel[15:0], r);
    chk(r == NRDY, "R4", 32'(r), 32'(NRDY));
    n = 0;
    while (n < 40) begin
      xchg(pw, r);
      if (r != NRDY) break;
      n++;
    end
    chk(n == WAIT + 1, "R4", 32'(n), 32'(WAIT + 1));
    if (!hit) begin
      chk(r == BERR, "R7", 32'(r), 32'(BERR));
    end else begin
      hi = r[15:0];
      chk(r[16] == 1'b0, "R5", 32'(r), 32'({1'b0, hi}));
      xchg(pw, r);
      chk(r[16] == 1'b0, "R5", 32'(r), 32'({1'b0, r[15:0]}));
      val = {hi, r[15:0]};
      m   = (32 - 8 * (k % 4) >= 32) ? 32'hFFFF_FFFF : ((32'h1 << (32 - 8 * (k % 4))) - 32'h1);
      raw = 32'h1357_9BDF * (k + 1);
      exp = raw & m;
      chk((val & m) == exp, "R6", val & m, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [16:0] r;
    bit prev;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(resp_o == NRDY, "R9", 32'(resp_o), 32'(NRDY));
    chk(resp_o == 17'h10000, "R2", 32'(resp_o), 32'h10000);
    rst_ni = 1'b1;
    repeat (2) @(posedge clk);

    // R1: non-command words in idle are dropped
    xchg(16'h0000, r);
    chk(r == NRDY, "R1", 32'(r), 32'(NRDY));
    xchg(16'h2D81, r);
    chk(r == NRDY, "R1", 32'(r), 32'(NRDY));
    xchg(16'hFFFF, r);
    chk(r == NRDY, "R1", 32'(r), 32'(NRDY));
    xchg(CMD ^ 16'h8000, r);
    chk(r == NRDY, "R1", 32'(r), 32'(NRDY));
    xchg(16'h0000, r);
    chk(r == NRDY, "R1", 32'(r), 32'(NRDY));
    rd(BASE, 1, 0);

    // R2: bus-error code
    rd(32'h0000_0001, 1, 0);

    // sweep around the mapped range, standalone and chained (R8)
    prev = 0;
    for (int s = -2; s < int'(N * STRIDE) + 2; s++) begin
      for (int c = 0; c < 2; c++) begin
        rd(BASE + 32'(s), !prev, c[0]);
        prev = c[0];
      end
    end
    rd(32'hFFFF_0C00, !prev, 1);
    rd(32'h0001_0C00, 0, 1);
    rd(32'h0000_0000, 0, 1);
    rd(BASE + 32'(STRIDE), 0, 0);

    // R9: reset mid-operand
    xchg(CMD, r);
    xchg(16'h0000, r);
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk(resp_o == NRDY, "R9", 32'(resp_o), 32'(NRDY));
    rst_ni = 1'b1;
    rd(BASE + 32'(2 * STRIDE), 1, 0);

    // R9: reset during the access wait
    xchg(CMD, r);
    xchg(16'h0000, r);
    xchg(16'h0C04, r);
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(resp_o == NRDY, "R9", 32'(resp_o), 32'(NRDY));
    rst_ni = 1'b1;
    xchg(16'h0000, r);
    chk(r == NRDY, "R9", 32'(r), 32'(NRDY));
    rd(BASE + 32'(3 * STRIDE), 1, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule